// File: doc/BRIEF.md
# Receive Descriptor Chaining Engine

This block walks a ring of host-owned receive descriptors and spreads each incoming packet across one or more host buffers. It tracks a current descriptor and, through a single lookahead poll, the ownership and length of the descriptor that follows it. Packet bytes are turned into buffer write commands addressed by descriptor index and byte offset. Whenever a buffer fills or the packet ends, the engine returns that buffer to the host with a short write-back sequence.

Descriptor reads are simplified: a one-cycle poll request carrying a ring index, and a later response carrying an ownership bit and a buffer length. Only one poll is outstanding at a time. Write-backs use one valid/ready port. Each write-back names a descriptor index, a field (status, message count or ownership), and a data word. The ownership word is always the last one sent for a descriptor. Buffer lengths supplied by the host are nonzero.

Top module: `rxdesc_chain`

## Requirements
- R1: While reset is asserted, rdValid, byteReady, wbValid and bufWrValid are all low.
- R2: Until a poll of the current descriptor returns owned, the engine keeps polling that same index and holds byteReady low. Bytes offered during this time produce no buffer write.
- R3: Once the current descriptor is owned, a single poll of the following index is issued. Byte intake starts right after that poll is issued, without waiting for its response.
- R4: Each accepted byte produces one buffer write carrying the current descriptor index, offsets rising from 0, and the byte value.
- R5: When the packet ends inside a buffer, the write-back sequence is status, then count, then ownership (data 0). Status bit 0 (end of packet) is set, and status bit 1 is set when this buffer is the packet's first. The count equals the packet's total byte count.
- R6: When a buffer fills before the end of the packet and the stored lookahead says the next descriptor is owned, the engine writes back status with bit 0 clear and then ownership. It then continues at offset 0 of the next index.
- R7: When a buffer fills before the end of the packet and the next descriptor is not owned, the rest of the packet is discarded with no buffer writes. At the packet's last byte the engine writes status with bit 2 (buffer error) and bit 3 (overflow) set, then ownership. No count is written.
- R8: The lookahead of a given descriptor is issued once. It is not repeated while that buffer is current, even if the host grants the descriptor afterwards.
- R9: After a packet, the engine moves to the following index. If the stored lookahead said owned, it starts the next packet without polling that index again and looks ahead to the index after it. Otherwise it polls the new index as in R2.
- R10: The ring index wraps from RING_LEN-1 back to 0.
- R11: While wbReady is low, a pending write-back keeps its valid, field and data unchanged.
- R12: A packet whose last byte lands exactly in the last slot of a buffer completes normally, as in R5, with no error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdValid | output | 1 | One-cycle descriptor poll request |
| rdIdx | output | IDX_W | Ring index being polled |
| rdRspValid | input | 1 | Poll response strobe |
| rdRspOwn | input | 1 | Response: descriptor owned by the engine |
| rdRspLen | input | LEN_W | Response: buffer length in bytes |
| byteValid | input | 1 | Receive byte available |
| byteData | input | DATA_W | Receive byte |
| byteLast | input | 1 | Byte is the packet's last |
| byteReady | output | 1 | Byte taken on this clock edge when valid |
| bufWrValid | output | 1 | Buffer write command |
| bufWrIdx | output | IDX_W | Descriptor index of the write |
| bufWrOff | output | LEN_W | Byte offset inside the buffer |
| bufWrData | output | DATA_W | Byte written |
| wbValid | output | 1 | Descriptor write-back request |
| wbReady | input | 1 | Write-back accepted |
| wbIdx | output | IDX_W | Descriptor index written back |
| wbField | output | 2 | 0 status, 1 message count, 2 ownership |
| wbData | output | CNT_W | Write-back data word |

## Verification
The hardest case to reach is a lookahead result that has gone stale. In this case the host grants the next descriptor after its only poll has already come back not owned. A packet must then overrun the current buffer, and the engine must still discard data rather than poll again. The bench serves polls from a host table it edits at chosen moments. It lets one packet finish, waits for the lookahead response of the following descriptor, then grants that descriptor and sends a packet longer than the current buffer. Ownership words taken from the write-back port clear the table, so later packets meet a ring whose state was left by earlier ones. This exercises the wrap, the chaining and the re-poll paths in one continuous run.

// File: rtl/rxdesc_chain_pkg.sv
package rxdesc_chain_pkg;

  typedef enum logic [1:0] {
    F_STAT = 2'd0,
    F_CNT  = 2'd1,
    F_OWN  = 2'd2
  } wbField_e;

  typedef enum logic [3:0] {
    S_START, S_POLL, S_PWAIT, S_ARM, S_RELOOK,
    S_FILL, S_FULL, S_DROP, S_WB, S_ADV
  } state_e;

  typedef enum logic [1:0] {
    K_END, K_CHAIN, K_ERR
  } kind_e;

  // status word bit positions (host software decodes these)
  localparam int ST_ENP  = 0;
  localparam int ST_STP  = 1;
  localparam int ST_BUFF = 2;
  localparam int ST_OFLO = 3;

  typedef struct packed {
    logic pollCur;
    logic pollNext;
    logic startPkt;
    logic takeByte;
    logic advance;
  } strobe_t;

endpackage

// File: rtl/rxdesc_chain_dp.sv
module rxdesc_chain_dp
  import rxdesc_chain_pkg::*;
#(
  parameter int RING_LEN = 8,
  parameter int LEN_W    = 12,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(RING_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              rdRspValid,
  input  logic              rdRspOwn,
  input  logic [LEN_W-1:0]  rdRspLen,
  input  logic [DATA_W-1:0] byteData,
  output logic              rdValid,
  output logic [IDX_W-1:0]  rdIdx,
  output logic              bufWrValid,
  output logic [LEN_W-1:0]  bufWrOff,
  output logic [DATA_W-1:0] bufWrData,
  output logic [IDX_W-1:0]  curIdx,
  output logic              lastSlot,
  output logic              laDone,
  output logic              nextOwn,
  output logic              firstBuf,
  output logic [CNT_W-1:0]  msgCnt
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);

  logic [LEN_W-1:0] curLen;
  logic [LEN_W-1:0] offset;
  logic [LEN_W-1:0] nextLen;
  logic             pendCur;
  logic             pendNext;
  logic [IDX_W-1:0] nextIdx;
  logic [LEN_W:0]   offPlus;

  assign nextIdx  = (curIdx == LAST_IDX) ? '0 : curIdx + IDX_W'(1);
  assign offPlus  = {1'b0, offset} + (LEN_W+1)'(1);
  assign lastSlot = (offPlus == {1'b0, curLen});

  assign rdValid    = strb.pollCur | strb.pollNext;
  assign rdIdx      = strb.pollCur ? curIdx : nextIdx;
  assign bufWrValid = strb.takeByte;
  assign bufWrOff   = offset;
  assign bufWrData  = byteData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx   <= '0;
      curLen   <= '0;
      offset   <= '0;
      msgCnt   <= '0;
      nextLen  <= '0;
      nextOwn  <= 1'b0;
      laDone   <= 1'b0;
      pendCur  <= 1'b0;
      pendNext <= 1'b0;
      firstBuf <= 1'b0;
    end else begin
      if (strb.pollCur)  pendCur  <= 1'b1;
      if (strb.pollNext) pendNext <= 1'b1;
      if (rdRspValid && pendCur) begin
        pendCur <= 1'b0;
        curLen  <= rdRspLen;
      end
      if (rdRspValid && pendNext) begin
        pendNext <= 1'b0;
        nextOwn  <= rdRspOwn;
        nextLen  <= rdRspLen;
        laDone   <= 1'b1;
      end
      if (strb.startPkt) begin
        msgCnt   <= '0;
        offset   <= '0;
        firstBuf <= 1'b1;
      end
      if (strb.takeByte) begin
        offset <= offset + LEN_W'(1);
        msgCnt <= msgCnt + CNT_W'(1);
      end
      if (strb.advance) begin
        curIdx   <= nextIdx;
        curLen   <= nextLen;
        offset   <= '0;
        laDone   <= 1'b0;
        firstBuf <= 1'b0;
      end
    end
  end

  AST_LA_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.pollNext |-> (!laDone && !pendNext)); // R8

  AST_WR_IN_BUF: assert property (@(posedge clk) disable iff (!rstN)
    bufWrValid |-> (offset < curLen)); // R4

endmodule

// File: rtl/rxdesc_chain_ctl.sv
module rxdesc_chain_ctl
  import rxdesc_chain_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdRspValid,
  input  logic             rdRspOwn,
  input  logic             byteValid,
  input  logic             byteLast,
  input  logic             wbReady,
  input  logic             lastSlot,
  input  logic             laDone,
  input  logic             nextOwn,
  input  logic             firstBuf,
  input  logic [CNT_W-1:0] msgCnt,
  output strobe_t          strb,
  output logic             byteReady,
  output logic             wbValid,
  output wbField_e         wbField,
  output logic [CNT_W-1:0] wbData
);

  state_e   state;
  kind_e    kind;
  wbField_e step;
  logic [CNT_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_START;
      kind  <= K_END;
      step  <= F_STAT;
    end else begin
      case (state)
        S_START: state <= S_POLL;
        S_POLL:  state <= S_PWAIT;
        S_PWAIT: if (rdRspValid) state <= rdRspOwn ? S_ARM : S_POLL;
        S_ARM, S_RELOOK: state <= S_FILL;
        S_FILL: if (byteValid) begin
          if (byteLast) begin
            kind  <= K_END;
            step  <= F_STAT;
            state <= S_WB;
          end else if (lastSlot) begin
            state <= S_FULL;
          end
        end
        S_FULL: if (laDone) begin
          if (nextOwn) begin
            kind  <= K_CHAIN;
            step  <= F_STAT;
            state <= S_WB;
          end else begin
            state <= S_DROP;
          end
        end
        S_DROP: if (byteValid && byteLast) begin
          kind  <= K_ERR;
          step  <= F_STAT;
          state <= S_WB;
        end
        S_WB: if (wbReady) begin
          case (step)
            F_STAT:  step <= (kind == K_END) ? F_CNT : F_OWN;
            F_CNT:   step <= F_OWN;
            default: state <= S_ADV;
          endcase
        end
        S_ADV: if (laDone) begin
          if (kind == K_CHAIN)  state <= S_RELOOK;
          else if (nextOwn)     state <= S_ARM;
          else                  state <= S_POLL;
        end
        default: state <= S_START;
      endcase
    end
  end

  always_comb begin
    statusWord          = '0;
    statusWord[ST_ENP]  = (kind == K_END);
    statusWord[ST_STP]  = firstBuf;
    statusWord[ST_BUFF] = (kind == K_ERR);
    statusWord[ST_OFLO] = (kind == K_ERR);
  end

  always_comb begin
    strb.pollCur  = (state == S_POLL);
    strb.pollNext = (state == S_ARM) || (state == S_RELOOK);
    strb.startPkt = (state == S_ARM);
    strb.takeByte = (state == S_FILL) && byteValid;
    strb.advance  = (state == S_ADV) && laDone;
    byteReady     = (state == S_FILL) || (state == S_DROP);
    wbValid       = (state == S_WB);
    wbField       = step;
    case (step)
      F_STAT:  wbData = statusWord;
      F_CNT:   wbData = msgCnt;
      default: wbData = '0;
    endcase
  end

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbField) && $stable(wbData))); // R11

  AST_OWN_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbReady && wbField == F_OWN) |=> !wbValid); // R5

  AST_NO_INTAKE_IN_WB: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> !byteReady); // R7

endmodule

// File: rtl/rxdesc_chain.sv
module rxdesc_chain
  import rxdesc_chain_pkg::*;
#(
  parameter int RING_LEN = 8,
  parameter int LEN_W    = 12,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(RING_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              rdValid,
  output logic [IDX_W-1:0]  rdIdx,
  input  logic              rdRspValid,
  input  logic              rdRspOwn,
  input  logic [LEN_W-1:0]  rdRspLen,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteLast,
  output logic              byteReady,
  output logic              bufWrValid,
  output logic [IDX_W-1:0]  bufWrIdx,
  output logic [LEN_W-1:0]  bufWrOff,
  output logic [DATA_W-1:0] bufWrData,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [1:0]        wbField,
  output logic [CNT_W-1:0]  wbData
);

  strobe_t          strb;
  logic [IDX_W-1:0] curIdx;
  logic             lastSlot;
  logic             laDone;
  logic             nextOwn;
  logic             firstBuf;
  logic [CNT_W-1:0] msgCnt;
  wbField_e         fieldSel;

  rxdesc_chain_dp #(
    .RING_LEN(RING_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdRspValid(rdRspValid), .rdRspOwn(rdRspOwn), .rdRspLen(rdRspLen),
    .byteData(byteData),
    .rdValid(rdValid), .rdIdx(rdIdx),
    .bufWrValid(bufWrValid), .bufWrOff(bufWrOff), .bufWrData(bufWrData),
    .curIdx(curIdx), .lastSlot(lastSlot), .laDone(laDone),
    .nextOwn(nextOwn), .firstBuf(firstBuf), .msgCnt(msgCnt)
  );

  rxdesc_chain_ctl #(.CNT_W(CNT_W)) ctl (
    .clk(clk), .rstN(rstN),
    .rdRspValid(rdRspValid), .rdRspOwn(rdRspOwn),
    .byteValid(byteValid), .byteLast(byteLast), .wbReady(wbReady),
    .lastSlot(lastSlot), .laDone(laDone), .nextOwn(nextOwn),
    .firstBuf(firstBuf), .msgCnt(msgCnt),
    .strb(strb), .byteReady(byteReady),
    .wbValid(wbValid), .wbField(fieldSel), .wbData(wbData)
  );

  assign bufWrIdx = curIdx;
  assign wbIdx    = curIdx;
  assign wbField  = fieldSel;

endmodule

// File: tb/rxdesc_chain_test.sv
`timescale 1ns/1ps
module rxdesc_chain_test;

  localparam int RING = 4;
  localparam int IW   = 2;
  localparam int LW   = 12;
  localparam int CW   = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdValid;
  logic [IW-1:0] rdIdx;
  logic          rdRspValid, rdRspOwn;
  logic [LW-1:0] rdRspLen;
  logic          byteValid = 1'b0, byteLast = 1'b0;
  logic [7:0]    byteData = 8'h0;
  logic          byteReady, bufWrValid;
  logic [IW-1:0] bufWrIdx;
  logic [LW-1:0] bufWrOff;
  logic [7:0]    bufWrData;
  logic          wbValid, wbReady;
  logic [IW-1:0] wbIdx;
  logic [1:0]    wbField;
  logic [CW-1:0] wbData;

  rxdesc_chain #(.RING_LEN(RING), .LEN_W(LW), .CNT_W(CW), .DATA_W(8)) uut (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdIdx(rdIdx),
    .rdRspValid(rdRspValid), .rdRspOwn(rdRspOwn), .rdRspLen(rdRspLen),
    .byteValid(byteValid), .byteData(byteData), .byteLast(byteLast),
    .byteReady(byteReady), .bufWrValid(bufWrValid), .bufWrIdx(bufWrIdx),
    .bufWrOff(bufWrOff), .bufWrData(bufWrData), .wbValid(wbValid),
    .wbReady(wbReady), .wbIdx(wbIdx), .wbField(wbField), .wbData(wbData)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;

  logic          hostOwn [RING];
  logic [LW-1:0] hostLen [RING];

  int pollLog [256];
  int pollN = 0;
  int rspCnt = 0;
  logic [IW-1:0] rspIdx;

  int wrIdx [64], wrOff [64], wrDat [64], wrOut [64];
  int wrN = 0;
  int wbI [64], wbF [64], wbD [64];
  int wbN = 0;
  logic wbStall = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pollsOf(input int idx);
    int n = 0;
    for (int i = 0; i < pollN; i++) if (pollLog[i] == idx) n++;
    return n;
  endfunction

  task automatic clearLogs();
    pollN = 0; wrN = 0; wbN = 0;
  endtask

  // poll responder: answers each poll from the host table after 6 cycles
  initial begin
    rdRspValid = 1'b0; rdRspOwn = 1'b0; rdRspLen = '0;
    forever begin
      @(negedge clk);
      rdRspValid = 1'b0;
      if (rspCnt > 0) begin
        rspCnt--;
        if (rspCnt == 0) begin
          rdRspValid = 1'b1;
          rdRspOwn   = hostOwn[rspIdx];
          rdRspLen   = hostLen[rspIdx];
        end
      end
      if (rstN && rdValid) begin
        if (pollN < 256) begin pollLog[pollN] = int'(rdIdx); pollN++; end
        rspIdx = rdIdx;
        rspCnt = 6;
      end
    end
  end

  // write-back sink: logs accepted words, clears host ownership on ownership writes
  initial begin
    wbReady = 1'b1;
    forever begin
      @(negedge clk);
      wbReady = wbStall ? ~wbReady : 1'b1;
      #1;
      if (rstN && wbValid && wbReady) begin
        if (wbN < 64) begin
          wbI[wbN] = int'(wbIdx); wbF[wbN] = int'(wbField); wbD[wbN] = int'(wbData);
          wbN++;
        end
        if (wbField == 2'd2) hostOwn[wbIdx] = 1'b0;
      end
    end
  end

  task automatic sendPacket(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteData = base + 8'(i); byteLast = (i == n-1);
      #1;
      while (!byteReady) begin @(negedge clk); #1; end
      if (bufWrValid && wrN < 64) begin
        wrIdx[wrN] = int'(bufWrIdx); wrOff[wrN] = int'(bufWrOff);
        wrDat[wrN] = int'(bufWrData); wrOut[wrN] = (rspCnt > 0) ? 1 : 0;
        wrN++;
      end
    end
    @(negedge clk);
    byteValid = 1'b0; byteLast = 1'b0;
  endtask

  task automatic checkWb(input string tag, input int k, input int idx, input int fld, input int dat);
    chk({tag, " wb index"}, wbI[k], idx);
    chk({tag, " wb field"}, wbF[k], fld);
    chk({tag, " wb data"},  wbD[k], dat);
  endtask

  task automatic testReset();
    int quiet = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      if (rdValid || byteReady || wbValid || bufWrValid) quiet = 0;
    end
    chk("R1 outputs quiet in reset", quiet, 1);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testIdlePoll();
    int blocked = 1;
    clearLogs();
    repeat (30) @(negedge clk);
    byteValid = 1'b1; byteData = 8'h5A; byteLast = 1'b0;
    for (int i = 0; i < 10; i++) begin
      #1;
      if (byteReady || bufWrValid) blocked = 0;
      @(negedge clk);
    end
    byteValid = 1'b0;
    chk("R2 bytes blocked while unowned", blocked, 1);
    chk("R2 repeated polls of index 0", (pollN >= 4) ? 1 : 0, 1);
    chk("R2 only index 0 polled", pollsOf(0), pollN);
  endtask

  task automatic testNormal();
    int errs = 0;
    clearLogs();
    hostLen[0] = 16; hostOwn[0] = 1'b1;
    hostLen[1] = 4;  hostOwn[1] = 1'b1;
    hostLen[2] = 8;  hostOwn[2] = 1'b0;
    sendPacket(10, 8'h10);
    chk("R3 one lookahead of index 1", pollsOf(1), 1);
    chk("R3 first byte taken before lookahead reply", wrOut[0], 1);
    chk("R4 buffer write count", wrN, 10);
    for (int i = 0; i < 10; i++)
      if (wrIdx[i] != 0 || wrOff[i] != i || wrDat[i] != 16 + i) errs++;
    chk("R4 buffer write index/offset/data", errs, 0);
    pollN = 0;
    repeat (40) @(negedge clk);
    chk("R5 write-back words", wbN, 3);
    checkWb("R5 status", 0, 0, 0, 3);
    checkWb("R5 count", 1, 0, 1, 10);
    checkWb("R5 ownership last", 2, 0, 2, 0);
    chk("R9 owned next starts with lookahead of index 2", pollLog[0], 2);
    chk("R9 no re-poll of stored owned index 1", pollsOf(1), 0);
  endtask

  task automatic testOverrun();
    int errs = 0;
    clearLogs();
    hostOwn[2] = 1'b1;
    hostLen[3] = 4; hostOwn[3] = 1'b1;
    sendPacket(7, 8'h40);
    chk("R8 no second lookahead after late grant", pollN, 0);
    chk("R7 only buffer bytes written", wrN, 4);
    for (int i = 0; i < 4; i++)
      if (wrIdx[i] != 1 || wrOff[i] != i || wrDat[i] != 64 + i) errs++;
    chk("R7 kept bytes placement", errs, 0);
    repeat (40) @(negedge clk);
    chk("R7 write-back words", wbN, 2);
    checkWb("R7 error status", 0, 1, 0, 14);
    checkWb("R7 ownership", 1, 1, 2, 0);
    chk("R9 unowned next is polled", pollLog[0], 2);
    chk("R3 lookahead after granted poll", pollLog[1], 3);
  endtask

  task automatic testChainWrap();
    int errs = 0;
    int eI [7] = '{2, 2, 3, 3, 0, 0, 0};
    int eF [7] = '{0, 2, 0, 2, 0, 1, 2};
    int eD [7] = '{2, 0, 0, 0, 1, 14, 0};
    clearLogs();
    hostLen[0] = 16; hostOwn[0] = 1'b1;
    wbStall = 1'b1;
    sendPacket(14, 8'h80);
    repeat (60) @(negedge clk);
    wbStall = 1'b0;
    chk("R6 bytes over three buffers", wrN, 14);
    for (int i = 0; i < 14; i++) begin
      int xi = (i < 8) ? 2 : (i < 12) ? 3 : 0;
      int xo = (i < 8) ? i : (i < 12) ? i - 8 : i - 12;
      if (wrIdx[i] != xi || wrOff[i] != xo || wrDat[i] != 128 + i) errs++;
    end
    chk("R6 chained placement", errs, 0);
    chk("R10 lookahead wraps to index 0", pollLog[0], 0);
    chk("R10 next lookahead index 1", pollLog[1], 1);
    chk("R11 all words through stalled port", wbN, 7);
    for (int k = 0; k < 7; k++) checkWb("R6 chain sequence", k, eI[k], eF[k], eD[k]);
  endtask

  task automatic testExactFill();
    int errs = 0;
    clearLogs();
    hostLen[1] = 5; hostOwn[1] = 1'b1;
    sendPacket(5, 8'hC0);
    repeat (40) @(negedge clk);
    chk("R12 all bytes written", wrN, 5);
    for (int i = 0; i < 5; i++)
      if (wrIdx[i] != 1 || wrOff[i] != i) errs++;
    chk("R12 placement", errs, 0);
    chk("R12 write-back words", wbN, 3);
    checkWb("R12 status no error", 0, 1, 0, 3);
    checkWb("R12 count", 1, 1, 1, 5);
    checkWb("R12 ownership", 2, 1, 2, 0);
  endtask

  initial begin
    for (int i = 0; i < RING; i++) begin hostOwn[i] = 1'b0; hostLen[i] = 12'd8; end
    testReset();
    testIdlePoll();
    testNormal();
    testOverrun();
    testChainWrap();
    testExactFill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule